// File: doc/BRIEF.md
# Video Pixel Output Formatter

This block takes one pixel per clock, given as three 12-bit components plus horizontal sync, vertical sync and data-enable, and places its bits onto a 36-pin output bus. An 8-bit format code picks the pin layout:

- a single 4:2:2 word stream;
- two-lane 4:2:2;
- three-lane 4:4:4, at 8, 10 or 12 bits per component;
- double-data-rate variants, for which the block presents separate rising-phase and falling-phase words.

Every pin has an output enable. Pins that the chosen layout does not use are disabled and carry zero. The block only selects, orders and time-multiplexes bits. The physical double-rate output cells sit downstream.

The three component inputs play different roles by layout:

- `comp_hi` carries red.
- `comp_mid` carries green, luma, or the already-interleaved 4:2:2 word stream.
- `comp_lo` carries blue, or the 4:2:2 chroma sample (Cb and Cr alternating, as ordered upstream).

A new format code is adopted only on the sample where vertical sync rises, so a frame is never split between two layouts. Sync outputs pass through the same single register stage as the pixel words, so they stay aligned with the data.

Top module: `vid_out_fmt`

## Requirements
- R1: While rst_n is low at a clock edge, every pixel word, output enable, sync output and the format-error flag become 0, and the active format becomes code 0x00.
- R2: Codes 0x00, 0x01 and 0x02 (8, 10 and 12 bits) put the top N bits of comp_mid on pins 23 downward, enable only those pins, and drive the same word in both phases.
- R3: Code 0x06 puts comp_mid bits 11..2 on pins 23..14 and bits 1..0 on pins 29..28, enables only those twelve pins, and drives the same word in both phases.
- R4: Codes 0x80, 0x81 and 0x82 put the top N bits of comp_mid on pins 23 downward and the top N bits of comp_lo on pins 11 downward, with the same word in both phases.
- R5: Codes 0x40, 0x41 and 0x42 put the top N bits of comp_hi, comp_mid and comp_lo left-aligned from pins 35, 23 and 11, with the same word in both phases.
- R6: Codes 0x20, 0x21 and 0x22 drive the top N bits of comp_lo from pin 23 downward in the rising phase, and the top N bits of comp_mid on the same pins in the falling phase.
- R7: Codes 0x60, 0x61 and 0x62 use the R5 lane placement and pair active samples. The first sample after data-enable has been low is even. On each odd sample, the rising word becomes the even sample and the falling word becomes the odd sample. Otherwise the words hold their values.
- R8: Any other code disables and zeroes every pin and sets a format-error flag. The flag stays at 1 until reset, even after a valid code is adopted.
- R9: fmt_sel is adopted only on a sample where vs_i is 1 and was 0 on the previous sample, and that sample already uses the new code. At all other times a change of fmt_sel has no effect on the outputs.
- R10: Every output is registered once: outputs after a clock edge reflect the inputs sampled at that edge, and hs_o, vs_o and de_o equal hs_i, vs_i and de_i of the previous sample.
- R11: A pin whose output enable is 0 carries 0 in both phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_sel | input | 8 | Requested format code |
| comp_hi | input | 12 | Red component |
| comp_mid | input | 12 | Green, luma, or serial 4:2:2 word |
| comp_lo | input | 12 | Blue, or 4:2:2 chroma sample |
| hs_i | input | 1 | Horizontal sync in |
| vs_i | input | 1 | Vertical sync in |
| de_i | input | 1 | Data enable in |
| pix_rise | output | 36 | Rising-phase pin word |
| pix_fall | output | 36 | Falling-phase pin word |
| pix_oe | output | 36 | Per-pin output enable |
| hs_o | output | 1 | Aligned horizontal sync |
| vs_o | output | 1 | Aligned vertical sync |
| de_o | output | 1 | Aligned data enable |
| fmt_err | output | 1 | Sticky unknown-format flag |

## Verification
The hardest case to reach is the even/odd pairing of the double-rate 4:4:4 layout. The pairing depends on data-enable history rather than on the format code, so the phase is invisible until an odd sample lands. The stimulus first adopts that layout on a vertical-sync rise with data-enable low. It then feeds an odd-length run of active samples, drops data-enable for one cycle, and resumes. This shows that the unpaired sample is dropped and that pairing restarts at the line start. A second case holds vertical sync high while changing the code, so that a new code is present but no frame start occurs.

// File: rtl/vfmt_pkg.sv
// Shared types for the video pixel output formatter.
// Assumes: format codes are 8 bits, and widths are 8, 10 or 12 bits per component.
package vfmt_pkg;

    typedef enum logic [2:0] {
        LAY_SER,      // single-bus 4:2:2 word stream
        LAY_SER_ALT,  // 12-bit single bus with low bits moved
        LAY_SDR422,   // two-lane 4:2:2
        LAY_SDR444,   // three-lane 4:4:4
        LAY_DDR422,   // chroma rising, luma falling
        LAY_DDR444,   // even rising, odd falling
        LAY_NONE      // unknown code
    } layout_e;

    typedef struct packed {
        layout_e    lay;
        logic [3:0] wid;
    } mode_t;

    // Turn a format code into a layout and a bit width.
    function automatic mode_t decode_mode(input logic [7:0] code);
        mode_t m;
        m.lay = LAY_NONE;
        m.wid = 4'd8 + {1'b0, code[1:0], 1'b0};
        if (code == 8'h06) begin
            m.lay = LAY_SER_ALT;
            m.wid = 4'd12;
        end else if (code[1:0] != 2'b11) begin
            case (code[7:2])
                6'h00:   m.lay = LAY_SER;
                6'h20:   m.lay = LAY_SDR422;
                6'h10:   m.lay = LAY_SDR444;
                6'h08:   m.lay = LAY_DDR422;
                6'h18:   m.lay = LAY_DDR444;
                default: m.lay = LAY_NONE;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/vfmt_mode_ctl.sv
// Holds the active format code and updates it only at a frame start (vs rising).
// Gives the mode that applies to the current sample and keeps the sticky error flag.
// Assumes: vs_i is synchronous to clk.
module vfmt_mode_ctl
    import vfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fmt_sel,
    input  logic       vs_i,
    output mode_t      mode_now,
    output logic       fmt_err
);

    logic       vs_q;
    logic [7:0] code_q;
    logic [7:0] code_now;
    logic       vs_rise;
    logic       bad_now;

    // Pick the code for this sample: the new one on a vs rise, otherwise the held one.
    always_comb begin
        vs_rise  = vs_i && !vs_q;
        code_now = vs_rise ? fmt_sel : code_q;
        mode_now = decode_mode(code_now);
        bad_now  = (mode_now.lay == LAY_NONE);
    end

    // Store the code, the previous vs and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs_q    <= 1'b0;
            code_q  <= 8'h00;
            fmt_err <= 1'b0;
        end else begin
            vs_q    <= vs_i;
            code_q  <= code_now;
            fmt_err <= fmt_err | bad_now;
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(vs_i && !vs_q) |=> $stable(code_q)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err); // R8
    AST_BAD_CODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bad_now |=> fmt_err); // R8

endmodule

// File: rtl/vfmt_lane_map.sv
// Combinational pin map: places one pixel's components onto the bus for the given mode.
// Produces a rising word, a falling word and per-pin enables. Unused pins are zero.
// Assumes: CW >= 12, and mode.wid is 8, 10 or 12.
module vfmt_lane_map
    import vfmt_pkg::*;
#(
    parameter int CW = 12,
    localparam int PINS = 3 * CW
) (
    input  mode_t           mode,
    input  logic [CW-1:0]   c_hi,
    input  logic [CW-1:0]   c_mid,
    input  logic [CW-1:0]   c_lo,
    output logic [PINS-1:0] w_rise,
    output logic [PINS-1:0] w_fall,
    output logic [PINS-1:0] w_oe
);

    localparam int LL  = 0;
    localparam int LM  = CW;
    localparam int LH  = 2 * CW;
    localparam int ALT = 4;   // offset within the top lane for the relocated low bits

    logic [CW-1:0] mask;

    // Select the pins and bits for the active layout.
    always_comb begin
        mask   = ~({CW{1'b1}} >> mode.wid);
        w_rise = '0;
        w_fall = '0;
        w_oe   = '0;
        case (mode.lay)
            LAY_SER: begin
                w_rise[LM +: CW] = c_mid & mask;
                w_oe[LM +: CW]   = mask;
                w_fall           = w_rise;
            end
            LAY_SER_ALT: begin
                w_rise[LM+2 +: CW-2] = c_mid[CW-1:2];
                w_rise[LH+ALT +: 2]  = c_mid[1:0];
                w_oe[LM+2 +: CW-2]   = '1;
                w_oe[LH+ALT +: 2]    = 2'b11;
                w_fall               = w_rise;
            end
            LAY_SDR422: begin
                w_rise[LM +: CW] = c_mid & mask;
                w_rise[LL +: CW] = c_lo & mask;
                w_oe[LM +: CW]   = mask;
                w_oe[LL +: CW]   = mask;
                w_fall           = w_rise;
            end
            LAY_SDR444, LAY_DDR444: begin
                w_rise[LH +: CW] = c_hi & mask;
                w_rise[LM +: CW] = c_mid & mask;
                w_rise[LL +: CW] = c_lo & mask;
                w_oe[LH +: CW]   = mask;
                w_oe[LM +: CW]   = mask;
                w_oe[LL +: CW]   = mask;
                w_fall           = w_rise;
            end
            LAY_DDR422: begin
                w_rise[LM +: CW] = c_lo & mask;
                w_fall[LM +: CW] = c_mid & mask;
                w_oe[LM +: CW]   = mask;
            end
            default: begin
                w_rise = '0;
            end
        endcase
    end

endmodule

// File: rtl/vfmt_sync_dly.sv
// Fixed-length register chain for sync signals, matching the pixel pipeline depth.
// Assumes: STAGES >= 1.
module vfmt_sync_dly #(
    parameter int W      = 3,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES+1];

    assign stg[0] = d;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Move the sync bits one stage along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i+1] <= '0;
            else        stg[i+1] <= stg[i];
        end
    end

    assign q = stg[STAGES];

endmodule

// File: rtl/vid_out_fmt.sv
// Top level of the pixel output formatter.
// Maps each pixel onto the pin bus, pairs samples for the double-rate 4:4:4 layout,
// registers the pin words and enables, and delays sync by the same depth.
// Assumes: one pixel per clk, and de_i low for at least one cycle between lines.
module vid_out_fmt
    import vfmt_pkg::*;
#(
    parameter int CW = 12,
    localparam int PINS = 3 * CW,
    localparam int PIPE = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      fmt_sel,
    input  logic [CW-1:0]   comp_hi,
    input  logic [CW-1:0]   comp_mid,
    input  logic [CW-1:0]   comp_lo,
    input  logic            hs_i,
    input  logic            vs_i,
    input  logic            de_i,
    output logic [PINS-1:0] pix_rise,
    output logic [PINS-1:0] pix_fall,
    output logic [PINS-1:0] pix_oe,
    output logic            hs_o,
    output logic            vs_o,
    output logic            de_o,
    output logic            fmt_err
);

    mode_t           mode_now;
    logic            phase_q;
    logic [CW-1:0]   hold_hi, hold_mid, hold_lo;
    logic [PINS-1:0] cur_rise, cur_fall, cur_oe;
    logic [PINS-1:0] held_rise, held_fall, held_oe;
    logic            is_ddr444;

    vfmt_mode_ctl u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_sel  (fmt_sel),
        .vs_i     (vs_i),
        .mode_now (mode_now),
        .fmt_err  (fmt_err)
    );

    vfmt_lane_map #(.CW(CW)) u_map_cur (
        .mode   (mode_now),
        .c_hi   (comp_hi),
        .c_mid  (comp_mid),
        .c_lo   (comp_lo),
        .w_rise (cur_rise),
        .w_fall (cur_fall),
        .w_oe   (cur_oe)
    );

    vfmt_lane_map #(.CW(CW)) u_map_held (
        .mode   (mode_now),
        .c_hi   (hold_hi),
        .c_mid  (hold_mid),
        .c_lo   (hold_lo),
        .w_rise (held_rise),
        .w_fall (held_fall),
        .w_oe   (held_oe)
    );

    vfmt_sync_dly #(.W(3), .STAGES(PIPE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hs_i, vs_i, de_i}),
        .q     ({hs_o, vs_o, de_o})
    );

    assign is_ddr444 = (mode_now.lay == LAY_DDR444);

    // Track even/odd active samples; the phase restarts whenever de_i is low.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= de_i ? ~phase_q : 1'b0;
    end

    // Capture the even sample of a pair for the double-rate 4:4:4 layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi  <= '0;
            hold_mid <= '0;
            hold_lo  <= '0;
        end else if (is_ddr444 && de_i && !phase_q) begin
            hold_hi  <= comp_hi;
            hold_mid <= comp_mid;
            hold_lo  <= comp_lo;
        end
    end

    // Register the pin words and enables for the current layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_rise <= '0;
            pix_fall <= '0;
            pix_oe   <= '0;
        end else begin
            pix_oe <= cur_oe;
            if (is_ddr444) begin
                if (de_i && phase_q) begin
                    pix_rise <= held_rise;
                    pix_fall <= cur_rise;
                end else begin
                    pix_rise <= pix_rise & cur_oe;
                    pix_fall <= pix_fall & cur_oe;
                end
            end else begin
                pix_rise <= cur_rise;
                pix_fall <= cur_fall;
            end
        end
    end

    AST_UNUSED_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_rise | pix_fall) & ~pix_oe) == '0); // R11
    AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({hs_o, vs_o, de_o} == $past({hs_i, vs_i, de_i}))); // R10
    AST_BAD_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_now.lay == LAY_NONE) |=> (pix_oe == '0)); // R8
    AST_DDR_HELD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ddr444 && !de_i && $past(is_ddr444) && $past(rst_n)) |=> (pix_oe == held_oe)); // R7

endmodule

// File: tb/test_vid_out_fmt.sv
`timescale 1ns/1ps
module test_vid_out_fmt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fmt_sel = 8'h00;
    logic [11:0] comp_hi = '0, comp_mid = '0, comp_lo = '0;
    logic        hs_i = 1'b0, vs_i = 1'b0, de_i = 1'b0;
    logic [35:0] pix_rise, pix_fall, pix_oe;
    logic        hs_o, vs_o, de_o, fmt_err;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vid_out_fmt i_vid_out_fmt (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel),
        .comp_hi(comp_hi), .comp_mid(comp_mid), .comp_lo(comp_lo),
        .hs_i(hs_i), .vs_i(vs_i), .de_i(de_i),
        .pix_rise(pix_rise), .pix_fall(pix_fall), .pix_oe(pix_oe),
        .hs_o(hs_o), .vs_o(vs_o), .de_o(de_o), .fmt_err(fmt_err)
    );

    // Each vector: {code, rise, fall, oe} for hi=ABC, mid=5E7, lo=3D9.
    localparam int NV = 14;
    localparam logic [115:0] VEC [NV] = '{
        {8'h00, 36'h0005E0000, 36'h0005E0000, 36'h000FF0000},
        {8'h01, 36'h0005E4000, 36'h0005E4000, 36'h000FFC000},
        {8'h02, 36'h0005E7000, 36'h0005E7000, 36'h000FFF000},
        {8'h06, 36'h0305E4000, 36'h0305E4000, 36'h030FFC000},
        {8'h80, 36'h0005E03D0, 36'h0005E03D0, 36'h000FF0FF0},
        {8'h81, 36'h0005E43D8, 36'h0005E43D8, 36'h000FFCFFC},
        {8'h82, 36'h0005E73D9, 36'h0005E73D9, 36'h000FFFFFF},
        {8'h40, 36'hAB05E03D0, 36'hAB05E03D0, 36'hFF0FF0FF0},
        {8'h41, 36'hABC5E43D8, 36'hABC5E43D8, 36'hFFCFFCFFC},
        {8'h42, 36'hABC5E73D9, 36'hABC5E73D9, 36'hFFFFFFFFF},
        {8'h20, 36'h0003D0000, 36'h0005E0000, 36'h000FF0000},
        {8'h21, 36'h0003D8000, 36'h0005E4000, 36'h000FFC000},
        {8'h22, 36'h0003D9000, 36'h0005E7000, 36'h000FFF000},
        {8'h13, 36'h000000000, 36'h000000000, 36'h000000000}
    };

    function automatic string req_of(input logic [7:0] c);
        case (c)
            8'h00, 8'h01, 8'h02: return "R2";
            8'h06:               return "R3";
            8'h80, 8'h81, 8'h82: return "R4";
            8'h40, 8'h41, 8'h42: return "R5";
            8'h20, 8'h21, 8'h22: return "R6";
            default:             return "R8";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pix(input logic [11:0] h, input logic [11:0] m, input logic [11:0] l);
        comp_hi = h; comp_mid = m; comp_lo = l;
    endtask

    // Adopt a code: vs low for one sample, then a rising sample carrying the code.
    task automatic adopt(input logic [7:0] code);
        vs_i = 1'b0; de_i = 1'b0;
        step();
        vs_i = 1'b1; fmt_sel = code;
        step();
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        set_pix(12'hABC, 12'h5E7, 12'h3D9);
        hs_i = 1'b1; vs_i = 1'b1; de_i = 1'b1; fmt_sel = 8'h42;
        repeat (3) step();
        // R1: reset state
        chk("R1", "rise", pix_rise, '0);
        chk("R1", "oe", pix_oe, '0);
        chk("R1", "err", {35'd0, fmt_err}, 36'd0);
        chk("R1", "sync", {33'd0, hs_o, vs_o, de_o}, 36'd0);
        vs_i = 1'b0; hs_i = 1'b0; de_i = 1'b0;
        rst_n = 1'b1;
        step();
        // R1 / R9: after reset, code 0x00 is active while fmt_sel=0x42 is not adopted
        chk("R9", "default rise", pix_rise, 36'h0005E0000);
        chk("R1", "default oe", pix_oe, 36'h000FF0000);

        // Table walk: every layout and width
        for (int i = 0; i < NV; i++) begin
            logic [115:0] v;
            v = VEC[i];
            adopt(v[115:108]);
            chk(req_of(v[115:108]), "rise", pix_rise, v[107:72]);
            chk(req_of(v[115:108]), "fall", pix_fall, v[71:36]);
            chk(req_of(v[115:108]), "oe", pix_oe, v[35:0]);
            chk("R11", "unused pins", (pix_rise | pix_fall) & ~pix_oe, '0);
        end

        // R8: the error flag is set and stays set after a valid code
        chk("R8", "err set", {35'd0, fmt_err}, 36'd1);
        adopt(8'h42);
        chk("R8", "err sticky", {35'd0, fmt_err}, 36'd1);
        chk("R8", "valid after bad", pix_oe, 36'hFFFFFFFFF);

        // R9: a code change without a vs rise has no effect
        fmt_sel = 8'h80;
        step();
        chk("R9", "vs high no adopt", pix_oe, 36'hFFFFFFFFF);
        vs_i = 1'b0;
        step();
        chk("R9", "vs fall no adopt", pix_rise, 36'hABC5E73D9);

        // R7: double-rate 4:4:4 pairing
        adopt(8'h62);
        chk("R7", "entry hold", pix_rise, 36'hABC5E73D9);
        de_i = 1'b1; set_pix(12'h111, 12'h222, 12'h333);
        step();
        chk("R7", "even sample held", pix_rise, 36'hABC5E73D9);
        set_pix(12'h444, 12'h555, 12'h666);
        step();
        chk("R7", "pair rise", pix_rise, 36'h111222333);
        chk("R7", "pair fall", pix_fall, 36'h444555666);
        set_pix(12'h777, 12'h888, 12'h999);
        step();
        chk("R7", "unpaired hold", pix_rise, 36'h111222333);
        de_i = 1'b0;
        step();
        chk("R7", "blank hold", pix_fall, 36'h444555666);
        de_i = 1'b1; set_pix(12'hAAA, 12'hBBB, 12'hCCC);
        step();
        chk("R7", "restart even", pix_rise, 36'h111222333);
        set_pix(12'hDDD, 12'hEEE, 12'hFFF);
        step();
        chk("R7", "restart rise", pix_rise, 36'hAAABBBCCC);
        chk("R7", "restart fall", pix_fall, 36'hDDDEEEFFF);
        de_i = 1'b0;

        // R10: sync outputs follow inputs by one sample
        for (int k = 0; k < 8; k++) begin
            logic [2:0] p;
            p = 3'(k * 5 + 3);
            {hs_i, vs_i, de_i} = p;
            step();
            chk("R10", "sync align", {33'd0, hs_o, vs_o, de_o}, {33'd0, p});
        end

        // R1: reset clears the sticky flag and the bus
        rst_n = 1'b0;
        step();
        chk("R1", "err cleared", {35'd0, fmt_err}, 36'd0);
        chk("R1", "bus cleared", pix_oe | pix_rise | pix_fall, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule